// File: doc/BRIEF.md
# SCSI command execution engine

This block sits beside the register file of a SCSI initiator controller and turns the bits that software writes into the command register into actions. It handles three commands: disconnect, select and information transfer. When it finishes a command, it marks the command complete by clearing that command's bit. While it works it updates the status bits for connected, selection in progress, state change and transmit buffer empty. It also runs a small free-running phase counter in the low bits of the data status register.

The engine reads the current register values directly. It writes back only through per-bit set and clear strobes. The register file applies them on the clock edge as `reg <= (reg & ~clr) | set`, so a set wins over a clear of the same bit. The engine keeps one piece of state of its own: whether a target is connected, and which target that is.

It evaluates commands on every `tick_en` cycle and on the cycle after any command register write. Byte transfers by programmed I/O are carried out. Transfers that ask for DMA, channel reset and target-mode data requests are only flagged and stay pending. The real bus handshake lies outside the block and reports a won selection through one input.

Top module: `scsi_cmd_engine`

## Requirements
- R1: Disconnect (command bit 9) clears connection status bits CONN (bit 9) and SIP (bit 8) and clears command bit 9.
- R2: A disconnect while a target is linked sets state-change (connection status bit 10) and drops `linked`; while unlinked it leaves bit 10 alone.
- R3: Select (command bit 8) clears command bit 8, sets SIP, and clears `linked` and `link_id`. It records `sel_id` bits [2:0] as the pending target.
- R4: A transfer (command bit 7) starts only if command[6:4] equals connection status[6:4], command[1:0] equals data status[1:0] (after any tick advance), and the effective SIP is clear.
- R5: A started transfer with DMA (command bit 12) clear raises `tx_vld` for one cycle with `tx_byte` equal to `data_q`. It clears command bit 7 and sets transmit-empty (data status bit 6).
- R6: A started transfer with DMA set raises `dma_pend` and leaves command bit 7 set, with no `tx_vld`.
- R7: Data status bits [2:0] advance by one modulo 8 on each `tick_en` cycle and not on a write-triggered evaluation.
- R8: Evaluation happens only on a `tick_en` cycle or the cycle after `cmd_wr`. Otherwise no command strobe is issued.
- R9: Commands in one evaluation act in the order counter advance, disconnect, select, transfer. A select blocks a transfer in the same evaluation, and a disconnect clears SIP ahead of it.
- R10: `sel_won` with SIP set and no evaluation in that cycle sets `linked` and copies the pending target to `link_id`. It sets CONN and state-change and clears SIP. With SIP clear, `sel_won` is ignored.
- R11: Channel reset (command bit 10) or target request (command bit 11) raises `unsup` during an evaluation, and those bits stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Periodic engine tick |
| cmd_wr | input | 1 | Command register was written this cycle |
| sel_won | input | 1 | Bus side reports selection completed |
| cmd_q | input | 16 | Command register value |
| cst_q | input | 16 | Connection status register value |
| dst_q | input | 16 | Data status register value |
| sel_id | input | 3 | Selector register target ID |
| data_q | input | 8 | Data register byte |
| cmd_clr | output | 16 | Command bits to clear |
| cst_set | output | 16 | Connection status bits to set |
| cst_clr | output | 16 | Connection status bits to clear |
| dst_set | output | 16 | Data status bits to set |
| dst_clr | output | 16 | Data status bits to clear |
| tx_vld | output | 1 | A byte is sent by programmed I/O |
| tx_byte | output | 8 | Byte being sent |
| dma_pend | output | 1 | Transfer started but held for DMA |
| unsup | output | 1 | Unsupported command bit present |
| linked | output | 1 | A target is connected |
| link_id | output | 3 | ID of the connected target |

## Verification
The bench builds the engine with its default parameters: 16-bit registers, a 3-bit target ID, an 8-bit data byte and a 3-bit phase counter. With these values the counter wraps after eight ticks, so a short run reaches the modulo-8 boundary. The two-bit data phase compare also lines up with counter values the bench can set directly. The bench keeps its own register file that applies the strobes. It then compares register contents after each command against values worked out from the requirements, including the mixed-command orderings.

// File: rtl/scsi_cmd_engine.sv
module scsi_cmd_engine #(
  parameter int REG_W  = 16,
  parameter int ID_W   = 3,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3,
  parameter int PH_LO  = 4,
  parameter int PH_W   = 3,
  parameter int DP_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cmd_wr,
  input  logic              sel_won,
  input  logic [REG_W-1:0]  cmd_q,
  input  logic [REG_W-1:0]  cst_q,
  input  logic [REG_W-1:0]  dst_q,
  input  logic [ID_W-1:0]   sel_id,
  input  logic [DATA_W-1:0] data_q,
  output logic [REG_W-1:0]  cmd_clr,
  output logic [REG_W-1:0]  cst_set,
  output logic [REG_W-1:0]  cst_clr,
  output logic [REG_W-1:0]  dst_set,
  output logic [REG_W-1:0]  dst_clr,
  output logic              tx_vld,
  output logic [DATA_W-1:0] tx_byte,
  output logic              dma_pend,
  output logic              unsup,
  output logic              linked,
  output logic [ID_W-1:0]   link_id
);

  localparam int B_XFER = 7;
  localparam int B_SEL  = 8;
  localparam int B_DISC = 9;
  localparam int B_CRST = 10;
  localparam int B_TREQ = 11;
  localparam int B_DMA  = 12;
  localparam int S_SIP  = 8;
  localparam int S_CONN = 9;
  localparam int S_SCHG = 10;
  localparam int D_TXE  = 6;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic              wr_d;
  logic [ID_W-1:0]   pend_id;
  logic              eval;
  logic [CNT_W-1:0]  cnt_eff;
  logic              do_disc, do_sel, do_xfer;
  logic              sip_eff, ph_match, go;
  logic              won_ok;
  logic              unused_bits;

  assign eval    = tick_en | wr_d;
  assign cnt_eff = tick_en ? dst_q[CNT_W-1:0] + CNT_ONE : dst_q[CNT_W-1:0];
  assign do_disc = eval & cmd_q[B_DISC];
  assign do_sel  = eval & cmd_q[B_SEL];
  assign do_xfer = eval & cmd_q[B_XFER];
  assign sip_eff = cmd_q[B_SEL] | (~cmd_q[B_DISC] & cst_q[S_SIP]);
  assign ph_match = (cmd_q[PH_LO +: PH_W] == cst_q[PH_LO +: PH_W]) &&
                    (cmd_q[DP_W-1:0] == cnt_eff[DP_W-1:0]);
  assign go       = do_xfer & ph_match & ~sip_eff;
  assign won_ok   = sel_won & ~eval & cst_q[S_SIP];
  assign tx_vld   = go & ~cmd_q[B_DMA];
  assign dma_pend = go & cmd_q[B_DMA];
  assign tx_byte  = data_q;
  assign unsup    = eval & (cmd_q[B_CRST] | cmd_q[B_TREQ]);
  assign unused_bits = ^{cmd_q, cst_q, dst_q};

  always_comb begin
    cmd_clr = '0;
    cst_set = '0;
    cst_clr = '0;
    dst_set = '0;
    dst_clr = '0;
    if (tick_en) begin
      dst_clr[CNT_W-1:0] = '1;
      dst_set[CNT_W-1:0] = cnt_eff;
    end
    if (do_disc) begin
      cmd_clr[B_DISC] = 1'b1;
      cst_clr[S_CONN] = 1'b1;
      cst_clr[S_SIP]  = 1'b1;
      if (linked) cst_set[S_SCHG] = 1'b1;
    end
    if (do_sel) begin
      cmd_clr[B_SEL] = 1'b1;
      cst_set[S_SIP] = 1'b1;
    end
    if (tx_vld) begin
      cmd_clr[B_XFER] = 1'b1;
      dst_set[D_TXE]  = 1'b1;
    end
    if (won_ok) begin
      cst_set[S_CONN] = 1'b1;
      cst_set[S_SCHG] = 1'b1;
      cst_clr[S_SIP]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_d    <= 1'b0;
      linked  <= 1'b0;
      link_id <= '0;
      pend_id <= '0;
    end else begin
      wr_d <= cmd_wr;
      if (eval) begin
        if (do_disc) linked <= 1'b0;
        if (do_sel) begin
          linked  <= 1'b0;
          link_id <= '0;
          pend_id <= sel_id;
        end
      end else if (won_ok) begin
        linked  <= 1'b1;
        link_id <= pend_id;
      end
    end
  end

  p_disc_unlinks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && cmd_q[B_DISC]) |=> !linked);

  p_sel_clears_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && cmd_q[B_SEL]) |=> (!linked && link_id == '0));

  p_xfer_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> (cmd_q[PH_LO +: PH_W] == cst_q[PH_LO +: PH_W] && !cmd_q[B_SEL] &&
                (cmd_q[B_DISC] || !cst_q[S_SIP])));

  p_pio_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> (!cmd_q[B_DMA] && cmd_clr[B_XFER] && dst_set[D_TXE]));

  p_dma_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_pend |-> (!cmd_clr[B_XFER] && !tx_vld));

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |-> (dst_set[CNT_W-1:0] == dst_q[CNT_W-1:0] + CNT_ONE));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !$past(cmd_wr)) |-> (cmd_clr == '0 && !tx_vld && !dma_pend));

  p_schg_moves_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cst_set[S_SCHG] |=> (linked != $past(linked)));

endmodule

// File: tb/scsi_cmd_engine_tb.sv
module scsi_cmd_engine_tb;
  localparam logic [15:0] XFER = 16'h0080;
  localparam logic [15:0] SEL  = 16'h0100;
  localparam logic [15:0] DISC = 16'h0200;
  localparam logic [15:0] CRST = 16'h0400;
  localparam logic [15:0] TREQ = 16'h0800;
  localparam logic [15:0] DMA  = 16'h1000;
  localparam logic [15:0] SIP  = 16'h0100;
  localparam logic [15:0] CONN = 16'h0200;
  localparam logic [15:0] SCHG = 16'h0400;
  localparam logic [15:0] TXE  = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, sel_won = 1'b0;
  logic h_cmd_we = 1'b0, h_cst_we = 1'b0, h_dst_we = 1'b0;
  logic [15:0] h_d = '0;
  logic [15:0] cmd, cst, dst;
  logic [2:0] sel_id = '0;
  logic [7:0] data_q = '0;
  logic [15:0] cmd_clr, cst_set, cst_clr, dst_set, dst_clr;
  logic tx_vld, dma_pend, unsup, linked;
  logic [7:0] tx_byte;
  logic [2:0] link_id;
  int checks = 0, errors = 0;
  int tx_cnt = 0, dma_cnt = 0, uns_cnt = 0;
  logic [7:0] last_byte = '0;
  bit done = 0;

  always #10 clk = ~clk;

  scsi_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmd_wr(h_cmd_we),
    .sel_won(sel_won), .cmd_q(cmd), .cst_q(cst), .dst_q(dst),
    .sel_id(sel_id), .data_q(data_q), .cmd_clr(cmd_clr),
    .cst_set(cst_set), .cst_clr(cst_clr), .dst_set(dst_set),
    .dst_clr(dst_clr), .tx_vld(tx_vld), .tx_byte(tx_byte),
    .dma_pend(dma_pend), .unsup(unsup), .linked(linked), .link_id(link_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd <= '0; cst <= '0; dst <= '0;
    end else begin
      cmd <= h_cmd_we ? h_d : (cmd & ~cmd_clr);
      cst <= h_cst_we ? h_d : ((cst & ~cst_clr) | cst_set);
      dst <= h_dst_we ? h_d : ((dst & ~dst_clr) | dst_set);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_vld) begin tx_cnt++; last_byte = tx_byte; end
      if (dma_pend) dma_cnt++;
      if (unsup) uns_cnt++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [15:0] v);
    @(posedge clk); #2;
    h_d = v;
    h_cmd_we = (which == 0); h_cst_we = (which == 1); h_dst_we = (which == 2);
    @(posedge clk); #2;
    h_cmd_we = 0; h_cst_we = 0; h_dst_we = 0;
    if (which == 0) begin @(posedge clk); #2; end
  endtask

  task automatic tick1();
    @(posedge clk); #2 tick_en = 1;
    @(posedge clk); #2 tick_en = 0;
  endtask

  task automatic won1();
    @(posedge clk); #2 sel_won = 1;
    @(posedge clk); #2 sel_won = 0;
  endtask

  task automatic t_reset();
    check("R8 reset linked", {31'b0, linked}, 0);
    check("R8 reset link_id", {29'b0, link_id}, 0);
    wr(1, 16'h0730 | SIP);
    repeat (3) @(posedge clk);
    #2;
    check("R8 idle no strobes cst", {16'b0, cst}, {16'b0, 16'h0730 | SIP});
    check("R8 idle no tx", tx_cnt, 0);
  endtask

  task automatic t_counter();
    wr(0, 16'h0000);
    wr(2, 16'h0005);
    for (int i = 0; i < 9; i++) tick1();
    check("R7 counter wraps mod 8", {29'b0, dst[2:0]}, 6);
    wr(0, 16'h0000);
    check("R7 write eval keeps counter", {29'b0, dst[2:0]}, 6);
  endtask

  task automatic t_select();
    sel_id = 3'd5;
    wr(1, 16'h0000);
    wr(0, SEL);
    check("R3 select bit cleared", {16'b0, cmd}, 0);
    check("R3 SIP set", {16'b0, cst}, {16'b0, SIP});
    check("R3 unlinked", {31'b0, linked}, 0);
    check("R3 link_id zero", {29'b0, link_id}, 0);
  endtask

  task automatic t_won();
    sel_id = 3'd2;
    won1();
    check("R10 linked", {31'b0, linked}, 1);
    check("R10 link_id from select", {29'b0, link_id}, 5);
    check("R10 cst conn+schg", {16'b0, cst}, {16'b0, CONN | SCHG});
    wr(1, 16'h0000);
    won1();
    check("R10 ignored without SIP", {16'b0, cst}, 0);
    check("R10 ignored keeps id", {29'b0, link_id}, 5);
  endtask

  task automatic t_disc();
    wr(1, CONN | SIP);
    wr(0, DISC);
    check("R1 disc bit cleared", {16'b0, cmd}, 0);
    check("R2 linked disc gives schg", {16'b0, cst}, {16'b0, SCHG});
    check("R2 unlinked after disc", {31'b0, linked}, 0);
    wr(1, CONN | SIP);
    wr(0, DISC);
    check("R1 R2 unlinked disc no schg", {16'b0, cst}, 0);
  endtask

  task automatic t_pio();
    wr(2, 16'h0002);
    wr(1, 16'h0030);
    data_q = 8'hA5;
    wr(0, XFER | 16'h0032);
    check("R5 one byte sent", tx_cnt, 1);
    check("R5 byte value", {24'b0, last_byte}, 32'hA5);
    check("R5 xfer bit cleared", {16'b0, cmd}, 32'h0032);
    check("R5 txe set", {16'b0, dst}, {16'b0, TXE | 16'h0002});
  endtask

  task automatic t_mismatch();
    wr(2, 16'h0002);
    wr(1, 16'h0020);
    wr(0, XFER | 16'h0032);
    check("R4 conn phase mismatch", tx_cnt, 1);
    check("R4 xfer pending", {16'b0, cmd}, {16'b0, XFER | 16'h0032});
    wr(1, 16'h0030);
    wr(2, 16'h0001);
    wr(0, XFER | 16'h0032);
    check("R4 data phase mismatch", tx_cnt, 1);
    wr(1, 16'h0030 | SIP);
    wr(2, 16'h0002);
    wr(0, XFER | 16'h0032);
    check("R4 blocked by SIP", tx_cnt, 1);
  endtask

  task automatic t_dma();
    wr(1, 16'h0030);
    wr(2, 16'h0002);
    wr(0, XFER | DMA | 16'h0032);
    check("R6 dma flagged", dma_cnt, 1);
    check("R6 no byte", tx_cnt, 1);
    check("R6 bits stay", {16'b0, cmd}, {16'b0, XFER | DMA | 16'h0032});
  endtask

  task automatic t_order();
    wr(1, 16'h0030);
    wr(2, 16'h0002);
    wr(0, SEL | XFER | 16'h0032);
    check("R9 select blocks xfer", tx_cnt, 1);
    check("R9 xfer left", {16'b0, cmd}, {16'b0, XFER | 16'h0032});
    check("R9 SIP set", {16'b0, cst}, {16'b0, 16'h0030 | SIP});
    wr(0, DISC | XFER | 16'h0032);
    check("R9 disc then xfer runs", tx_cnt, 2);
    check("R9 cmd after disc+xfer", {16'b0, cmd}, 32'h0032);
    check("R9 cst after disc+xfer", {16'b0, cst}, 32'h0030);
  endtask

  task automatic t_unsup();
    wr(0, CRST);
    check("R11 reset flagged", uns_cnt, 1);
    check("R11 reset bit stays", {16'b0, cmd}, {16'b0, CRST});
    wr(0, TREQ);
    check("R11 target req flagged", uns_cnt, 2);
  endtask

  task automatic t_tick_cmp();
    wr(2, 16'h0000);
    wr(1, 16'h0030);
    data_q = 8'h3C;
    wr(0, XFER | 16'h0031);
    check("R7 write eval no advance no match", tx_cnt, 2);
    tick1();
    check("R7 tick compare after advance", tx_cnt, 3);
    check("R7 byte", {24'b0, last_byte}, 32'h3C);
    check("R8 tick cleared xfer", {16'b0, cmd}, 32'h0031);
    check("R7 dst after tick", {16'b0, dst}, {16'b0, TXE | 16'h0001});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_counter();
    t_select();
    t_won();
    t_disc();
    t_pio();
    t_mismatch();
    t_dma();
    t_order();
    t_unsup();
    t_tick_cmp();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule